// File: doc/BRIEF.md
# Dual-Mode Modular Butterfly for a Number-Theoretic Transform

This block is the arithmetic heart of a number-theoretic transform engine working modulo the prime q = 8380417 (2^23 − 2^13 + 1). On every clock it can accept one beat that carries:

- two 23-bit coefficients, a and b;
- a 23-bit twiddle w;
- the signed 24-bit difference a − b, which a neighbouring stage computes once for a pair of butterflies.

A per-beat mode bit picks the operation.

- **Forward (decimation-in-time) mode** returns the pair (a + b·w, a − b·w) mod q. The second result is not multiplied again. It is derived from 2a minus the first result.
- **Inverse (decimation-in-frequency) mode** returns the pair ((a + b)/2, (a − b)·w) mod q. The twiddle supplied in this mode already carries the factor 1/2 mod q. The halving of a + b needs no divider: it uses the two operand LSBs and a (q+1)/2 correction.

The unit is fully pipelined. A valid flag moves through it with a fixed latency of four clock edges, and the mode travels with its beat, so forward and inverse beats may be interleaved freely.

Top module: `ntt_bfly_dual`

## Requirements
- R1: In forward mode (`in_inv` = 0), `out_x` equals (a + b·w) mod q.
- R2: In forward mode, `out_y` equals (a − b·w) mod q, so that `out_x` + `out_y` is congruent to 2a.
- R3: In inverse mode (`in_inv` = 1), `out_x` equals (a + b)·(q+1)/2 mod q, which is the halved sum. This holds for every LSB combination of a and b, including sums that first land at or above q.
- R4: In inverse mode, `out_y` equals ((a − b)·w) mod q. `in_diff` is read as a two's-complement value, and a negative difference is lifted by q before the multiply.
- R5: Every valid output beat has both `out_x` and `out_y` in the range [0, q).
- R6: A beat captured with `in_valid` = 1 on edge k appears with `out_valid` = 1 right after edge k+3 (latency 4). The bench also exercises back-to-back beats with alternating modes, one per cycle.
- R7: The reset is synchronous and active-high. While `rst` is high and on the cycle after it, `out_valid`, `out_x` and `out_y` are 0. Beats in flight at a reset never emerge.
- R8: Cycles with `in_valid` = 0 produce no output beat, whatever values the data and mode inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_inv | input | 1 | 0 = forward butterfly, 1 = inverse butterfly |
| in_a | input | 23 | Coefficient a, in [0, q) |
| in_b | input | 23 | Coefficient b, in [0, q) |
| in_tw | input | 23 | Twiddle (inverse mode: pre-scaled by 1/2 mod q) |
| in_diff | input | 24 | Signed two's-complement a − b |
| out_valid | output | 1 | Output beat present |
| out_x | output | 23 | First result (forward: a+bw, inverse: (a+b)/2) |
| out_y | output | 23 | Second result (forward: a−bw, inverse: (a−b)w) |

## Verification
The bench aims at the following corner cases. Each comes with the symptom a faulty design would show.

- **Both coefficient LSBs set, and exactly one LSB set.** A wrong correction constant makes the halved sum off by one or by (q+1)/2.
- **a and b near q − 1.** The raw halved sum then exceeds q, so a missing final subtraction returns a value outside [0, q).
- **a = 0 with large b.** The difference is negative. Skipping the +q lift would multiply a huge unsigned pattern and give an unrelated product.
- **b = 0 or w = 0.** The forward pair must collapse to (a, a). A slip in the sign handling of 2a − A would give q + a or a negative wrap instead.

The bench also interleaves modes on consecutive cycles and resets with beats in flight. These checks expose a mode bit or valid flag that is out of step with its data.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  // Coefficient width and prime modulus q = 2^23 - 2^13 + 1
  parameter int unsigned COEF_W  = 23;
  parameter int unsigned MOD_Q   = 8380417;
  // Register stages between input capture and output (inclusive)
  parameter int unsigned BFLY_LAT = 4;
endpackage

// File: rtl/bfly_delay.sv
module bfly_delay #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(DEPTH); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];

  initial begin
    a_depth_nonzero_r6: assert (DEPTH >= 1) else $error("delay depth must be at least one");
  end
endmodule

// File: rtl/bfly_mulred.sv
module bfly_mulred #(
  parameter int unsigned CW = 23,
  parameter int unsigned Q  = 8380417
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] w,
  input  logic [CW-1:0] c,
  output logic [CW-1:0] r
);
  localparam int unsigned PW = 2 * CW + 1;
  localparam logic [CW-1:0] QV = CW'(Q);

  logic [PW-1:0] prod_q;
  logic [CW-1:0] r_q;

  // Stage 1: multiply-accumulate, stage 2: generic reduction
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      r_q    <= '0;
    end else begin
      prod_q <= PW'(x) * PW'(w) + PW'(c);
      r_q    <= CW'(prod_q % PW'(Q));
    end
  end

  assign r = r_q;

  p_red_range_r5: assert property (@(posedge clk) disable iff (rst) r_q < QV)
    else $error("reduced product out of range");
endmodule

// File: rtl/bfly_halfsum.sv
module bfly_halfsum #(
  parameter int unsigned CW = 23,
  parameter int unsigned Q  = 8380417
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] a,
  input  logic [CW-1:0] b,
  output logic [CW-1:0] h
);
  localparam int unsigned HALF_I = (Q + 1) / 2;
  localparam logic [CW:0] HALF = (CW+1)'(HALF_I);
  localparam logic [CW:0] QW   = (CW+1)'(Q);

  logic [CW:0]   corr;
  logic [CW:0]   raw_q;
  logic [CW-1:0] h_q;

  always_comb begin
    unique case ({a[0], b[0]})
      2'b11:         corr = (CW+1)'(1);
      2'b01, 2'b10:  corr = HALF;
      default:       corr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      h_q   <= '0;
    end else begin
      raw_q <= (CW+1)'(a[CW-1:1]) + (CW+1)'(b[CW-1:1]) + corr;
      h_q   <= (raw_q >= QW) ? CW'(raw_q - QW) : CW'(raw_q);
    end
  end

  assign h = h_q;

  p_half_double_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((64'(raw_q) * 64'd2) % 64'(Q)) == ((64'($past(a)) + 64'($past(b))) % 64'(Q)))
    else $error("halved sum not congruent to (a+b)/2");
endmodule

// File: rtl/ntt_bfly_dual.sv
module ntt_bfly_dual
  import bfly_pkg::*;
#(
  parameter int unsigned CW  = COEF_W,
  parameter int unsigned Q   = MOD_Q
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_inv,
  input  logic [CW-1:0] in_a,
  input  logic [CW-1:0] in_b,
  input  logic [CW-1:0] in_tw,
  input  logic [CW:0]   in_diff,
  output logic          out_valid,
  output logic [CW-1:0] out_x,
  output logic [CW-1:0] out_y
);
  localparam int unsigned DW  = CW + 1;
  localparam int unsigned TW  = CW + 3;
  localparam int unsigned LAT = BFLY_LAT;
  localparam logic [CW-1:0] QV  = CW'(Q);
  localparam logic [DW-1:0] QD  = DW'(Q);
  localparam logic [TW-1:0] QT  = TW'(Q);

  // Stage 0: input capture
  logic          v0, inv0;
  logic [CW-1:0] a0, b0, w0;
  logic [DW-1:0] d0;

  always_ff @(posedge clk) begin
    if (rst) begin
      v0 <= 1'b0; inv0 <= 1'b0;
      a0 <= '0; b0 <= '0; w0 <= '0; d0 <= '0;
    end else begin
      v0 <= in_valid; inv0 <= in_inv;
      a0 <= in_a; b0 <= in_b; w0 <= in_tw; d0 <= in_diff;
    end
  end

  // Multiplier operands: forward b*w + a, inverse (a-b lifted)*w
  logic [DW-1:0] d_lift;
  logic [CW-1:0] mul_x, mul_c;

  always_comb begin
    d_lift = d0[DW-1] ? (d0 + QD) : d0;
    mul_x  = inv0 ? d_lift[CW-1:0] : b0;
    mul_c  = inv0 ? '0 : a0;
  end

  logic [CW-1:0] prod_r, half_r, a2;
  logic          v2, inv2;

  bfly_mulred #(.CW(CW), .Q(Q)) u_mul (
    .clk(clk), .rst(rst), .x(mul_x), .w(w0), .c(mul_c), .r(prod_r)
  );

  bfly_halfsum #(.CW(CW), .Q(Q)) u_half (
    .clk(clk), .rst(rst), .a(a0), .b(b0), .h(half_r)
  );

  // Align pass-through operand and control with the two-stage units
  bfly_delay #(.WIDTH(CW + 2), .DEPTH(LAT - 2)) u_align (
    .clk(clk), .rst(rst), .d({v0, inv0, a0}), .q({v2, inv2, a2})
  );

  // Forward second result: 2a - A, folded into [0, q)
  logic signed [TW-1:0] diff2;
  logic [CW-1:0]        fwd_y;

  always_comb begin
    diff2 = $signed({2'b00, a2, 1'b0}) - $signed({3'b000, prod_r});
    if (diff2[TW-1])                 fwd_y = CW'(diff2 + $signed(QT));
    else if ($unsigned(diff2) >= QT) fwd_y = CW'(diff2 - $signed(QT));
    else                             fwd_y = CW'(diff2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0; out_x <= '0; out_y <= '0;
    end else begin
      out_valid <= v2;
      out_x     <= inv2 ? half_r : prod_r;
      out_y     <= inv2 ? prod_r : fwd_y;
    end
  end

  // Cycles since reset, so that $past never reaches into the reset window
  logic [$clog2(LAT+1)-1:0] warm_cnt;
  logic                     warm;

  always_ff @(posedge clk) begin
    if (rst)                         warm_cnt <= '0;
    else if (warm_cnt != ($clog2(LAT+1))'(LAT)) warm_cnt <= warm_cnt + 1'b1;
  end
  assign warm = (warm_cnt == ($clog2(LAT+1))'(LAT));

  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    warm |-> out_valid == $past(in_valid, LAT))
    else $error("valid latency broken");

  p_range_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_x < QV) && (out_y < QV))
    else $error("output out of [0,q)");

  p_fwd_pair_r2: assert property (@(posedge clk) disable iff (rst)
    (warm && out_valid && !$past(in_inv, LAT)) |->
      ((64'(out_x) + 64'(out_y)) % 64'(Q)) == ((64'($past(in_a, LAT)) * 64'd2) % 64'(Q)))
    else $error("forward pair does not sum to 2a");

  p_inv_half_r3: assert property (@(posedge clk) disable iff (rst)
    (warm && out_valid && $past(in_inv, LAT)) |->
      ((64'(out_x) * 64'd2) % 64'(Q)) ==
      ((64'($past(in_a, LAT)) + 64'($past(in_b, LAT))) % 64'(Q)))
    else $error("inverse halved sum wrong");

  p_rst_quiet_r7: assert property (@(posedge clk)
    rst |=> !out_valid && out_x == '0 && out_y == '0)
    else $error("outputs not cleared by reset");
endmodule

// File: tb/ntt_bfly_dual_test.sv
module ntt_bfly_dual_test;
  localparam int unsigned CW = 23;
  localparam longint Q = 8380417;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_inv = 1'b0;
  logic [CW-1:0] in_a = '0, in_b = '0, in_tw = '0;
  logic [CW:0]   in_diff = '0;
  logic          out_valid;
  logic [CW-1:0] out_x, out_y;

  always #5 clk = ~clk;

  ntt_bfly_dual uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_inv(in_inv),
    .in_a(in_a), .in_b(in_b), .in_tw(in_tw), .in_diff(in_diff),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
  );

  typedef struct {
    longint x;
    longint y;
    bit     inv;
    longint due;
  } exp_t;

  exp_t   sb[$];
  int     checks = 0;
  int     errors = 0;
  int     unexpected = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Driver: compute expected pair from the requirements and queue it
  task automatic send(input longint a, input longint b, input longint w, input bit inv);
    exp_t e;
    longint bw, dm;
    if (!inv) begin
      bw  = (b * w) % Q;
      e.x = (a + bw) % Q;            // R1
      e.y = (a + Q - bw) % Q;        // R2
    end else begin
      dm  = (a + Q - b) % Q;
      e.x = ((a + b) * ((Q + 1) / 2)) % Q;  // R3
      e.y = (dm * w) % Q;                   // R4
    end
    e.inv = inv;
    @(negedge clk);
    in_valid = 1'b1;
    in_inv   = inv;
    in_a     = CW'(a);
    in_b     = CW'(b);
    in_tw    = CW'(w);
    in_diff  = (CW+1)'(a - b);
    e.due    = cyc + 4;                     // R6: captured at next edge, out 3 edges later
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_inv   = $urandom % 2;
      in_a     = CW'($urandom);
      in_b     = CW'($urandom);
      in_tw    = CW'($urandom);
      in_diff  = (CW+1)'($urandom);
    end
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        unexpected++;
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(longint'(cyc) == e.due, "R6", "beat latency", cyc, e.due);
        check(out_x < Q && out_y < Q, "R5", "range", longint'(out_x) + longint'(out_y), 0);
        if (!e.inv) begin
          check(longint'(out_x) == e.x, "R1", "fwd out_x", out_x, e.x);
          check(longint'(out_y) == e.y, "R2", "fwd out_y", out_y, e.y);
        end else begin
          check(longint'(out_x) == e.x, "R3", "inv out_x", out_x, e.x);
          check(longint'(out_y) == e.y, "R4", "inv out_y", out_y, e.y);
        end
      end
    end
  end

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      summary_and_end();
    end
  end

  task automatic drain();
    for (int i = 0; i < 20 && sb.size() != 0; i++) @(negedge clk);
    check(sb.size() == 0, "R6", "queue drained", sb.size(), 0);
  endtask

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_x == '0 && out_y == '0, "R7", "reset outputs",
          longint'(out_valid) + longint'(out_x) + longint'(out_y), 0);
    rst = 1'b0;

    // R8: invalid cycles with noisy data
    idle(8);
    check(out_valid == 1'b0, "R8", "idle out_valid", out_valid, 0);
    check(unexpected == 0, "R8", "no beats from idle", unexpected, 0);

    // Corner cases in both modes, interleaved back to back
    for (int m = 0; m < 2; m++) begin
      send(5, 5, 1234567, m[0]);            // a = b
      send(777, 0, 99, m[0]);               // b = 0
      send(Q-1, Q-1, Q-1, m[0]);            // all at q-1
      send(0, Q-1, 7, m[0]);                // negative difference
      send(Q-1, 0, Q-1, m[0]);
      send(3, 9, 11, m[0]);                 // both LSBs odd
      send(2, 9, 11, m[0]);                 // one LSB odd
      send(Q-1, Q-2, 5, m[0]);              // halved sum over q
      send(123, 456, 0, m[0]);              // w = 0
      send(1, Q-1, 1, m[0]);
    end
    idle(1);
    for (int i = 0; i < 40; i++) send(Q - 1 - i, i, Q - 2, i[0]);   // R6 alternating modes
    idle(2);

    // Random beats with gaps
    for (int i = 0; i < 400; i++) begin
      send($urandom % Q, $urandom % Q, $urandom % Q, $urandom % 2);
      if (($urandom % 5) == 0) idle(1 + $urandom % 3);
    end
    idle(1);
    drain();

    // R7: reset with beats in flight
    send(100, 200, 300, 1'b0);
    send(400, 50, 60, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    sb.delete();
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R7", "valid during reset", out_valid, 0);
    rst = 1'b0;
    idle(6);
    check(unexpected == 0, "R7", "flushed beats never emerge", unexpected, 0);

    // After reset: a few more beats
    send(Q-1, 1, Q-1, 1'b1);
    send(Q-1, 1, Q-1, 1'b0);
    idle(1);
    drain();
    check(unexpected == 0, "R8", "unexpected output beats", unexpected, 0);

    done = 1'b1;
    summary_and_end();
  end
endmodule